// File: doc/BRIEF.md
# Interconnect Test Vector Generator

This block produces the parallel vectors that a board test drives onto a group of nets, one vector per step. Every net owns a serial code word, and each step exposes one bit of every code word side by side on `drive_vec`. Five coding schemes can be selected when a run starts. They trade sequence length against how well shorts, opens and stuck drivers can be told apart.

The same block checks the response. At each step the sensed vector is compared bit by bit against the vector being driven. A per-net mismatch vector is shown at once. Every mismatch seen at a step strobe is also folded into a sticky failure map, which lasts until the next start. Shifting the vectors into scan cells and the physical drive and sense are handled elsewhere.

Top module: `ict_vecgen`

## Requirements
- R1: After reset, `busy`, `done`, `drive_vec`, `mismatch` and `fail_map` are all zero.
- R2: A `start` pulse loads `mode_sel` and clears `fail_map`. One cycle later, `busy` is 1, `done` is 0 and step 0 is on `drive_vec`. Mode codes are: 0 counting, 1 modified counting, 2 true/complement, 3 extended true/complement, 4 walking one. Codes 5 to 7 run as counting. A `start` also restarts a run that is in progress, and it takes priority over `step`.
- R3: Counting uses W = ceil(log2 NETS) steps. At step k, net i drives bit W-1-k of the binary value i, so the most significant bit goes first.
- R4: Modified counting uses ceil(log2(NETS+2)) steps. Net i carries the value i+1, most significant bit first, so no net's code word is all zeros or all ones.
- R5: True/complement uses 2W steps. The counting steps come first, then their bitwise complements in the same order. Every net carries exactly W ones.
- R6: Extended true/complement uses 2W+2 steps. Step 0 drives all nets 0, step 1 drives all nets 1, and steps 2 onward repeat the true/complement sequence.
- R7: Walking one uses NETS steps. At step k, only net k is driven 1.
- R8: A `step` strobe while `busy` advances to the next step. The strobe on the last step clears `busy`, sets `done` and returns `drive_vec` to zero in the next cycle. `done` stays set until the next start. A `step` while idle changes nothing.
- R9: While `busy`, `mismatch` equals `sensed` XOR `drive_vec`. While idle, it is zero.
- R10: At each accepted step strobe, `fail_map` takes the OR of itself and `mismatch`. Bits never clear until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new sequence with the selected code |
| mode_sel | input | 3 | Coding scheme for the next sequence |
| step | input | 1 | Sensed vector valid for the current step; advance |
| sensed | input | NETS | Values received on the nets for the current step |
| drive_vec | output | NETS | Vector to drive for the current step |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last step completed |
| mismatch | output | NETS | Per-net difference between the sensed and driven values at this step |
| fail_map | output | NETS | Sticky per-net failure record for the run |

## Verification
The hardest case to reach is a failure map that holds mismatches from more than one step, or from one run into a restarted run. To produce it, the bench corrupts the sensed vector by inverting chosen nets at a single chosen step. It then checks that only those nets are set and that they stay set through the remaining clean steps. A start issued in the middle of a sequence, after a fault has been injected, shows that the map clears and that the new code begins at its own step 0. Per-net properties of the codes, such as no constant code word and balanced ones, are checked by collecting every observed vector across a run.

// File: rtl/itv_pkg.sv
package itv_pkg;

    typedef enum logic [2:0] {
        CODE_COUNT    = 3'd0,
        CODE_MODCOUNT = 3'd1,
        CODE_TRUECOMP = 3'd2,
        CODE_EXTTC    = 3'd3,
        CODE_WALK     = 3'd4
    } code_mode_e;

    typedef struct packed {
        logic busy;
        logic done;
    } run_state_t;

    function automatic int idx_bits(int nets);
        return (nets < 2) ? 1 : $clog2(nets);
    endfunction

    function automatic int seq_len(code_mode_e m, int nets);
        case (m)
            CODE_MODCOUNT: return $clog2(nets + 2);
            CODE_TRUECOMP: return 2 * idx_bits(nets);
            CODE_EXTTC:    return 2 * idx_bits(nets) + 2;
            CODE_WALK:     return nets;
            default:       return idx_bits(nets);
        endcase
    endfunction

    function automatic code_mode_e legal_mode(logic [2:0] raw);
        return (raw > 3'd4) ? CODE_COUNT : code_mode_e'(raw);
    endfunction

    // bit k of a code word of the given width, most significant bit first
    function automatic logic code_bit(int code, int width, int k);
        if (k < 0 || k >= width) return 1'b0;
        return ((code >> (width - 1 - k)) & 1) == 1;
    endfunction

endpackage

// File: rtl/itv_seq.sv
module itv_seq
    import itv_pkg::*;
#(
    parameter int NETS = 8,
    parameter int STW  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode_raw,
    input  logic              step,
    output code_mode_e        mode_q,
    output logic [STW-1:0]    idx,
    output run_state_t        st
);
    logic [STW-1:0] last_idx;

    always_comb last_idx = STW'(seq_len(mode_q, NETS) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CODE_COUNT;
            idx    <= '0;
            st     <= '0;
        end else if (start) begin
            mode_q  <= legal_mode(mode_raw);
            idx     <= '0;
            st.busy <= 1'b1;
            st.done <= 1'b0;
        end else if (step && st.busy) begin
            if (idx == last_idx) begin
                st.busy <= 1'b0;
                st.done <= 1'b1;
                idx     <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/itv_pattern.sv
module itv_pattern
    import itv_pkg::*;
#(
    parameter int NETS = 8,
    parameter int STW  = 5
) (
    input  code_mode_e        mode,
    input  logic [STW-1:0]    idx,
    input  logic              busy,
    output logic [NETS-1:0]   vec
);
    localparam int CW  = idx_bits(NETS);
    localparam int MCW = $clog2(NETS + 2);

    always_comb begin
        int k;
        k = int'(idx);
        for (int i = 0; i < NETS; i++) begin
            case (mode)
                CODE_MODCOUNT: vec[i] = code_bit(i + 1, MCW, k);
                CODE_TRUECOMP: vec[i] = (k < CW) ? code_bit(i, CW, k)
                                                 : !code_bit(i, CW, k - CW);
                CODE_EXTTC: begin
                    if (k < 2)           vec[i] = (k == 1);
                    else if (k < CW + 2) vec[i] = code_bit(i, CW, k - 2);
                    else                 vec[i] = !code_bit(i, CW, k - 2 - CW);
                end
                CODE_WALK:     vec[i] = (k == i);
                default:       vec[i] = code_bit(i, CW, k);
            endcase
            if (!busy) vec[i] = 1'b0;
        end
    end
endmodule

// File: rtl/itv_compare.sv
module itv_compare #(
    parameter int NETS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step,
    input  logic              busy,
    input  logic [NETS-1:0]   expected,
    input  logic [NETS-1:0]   sensed,
    output logic [NETS-1:0]   mismatch,
    output logic [NETS-1:0]   fail_map
);
    for (genvar i = 0; i < NETS; i++) begin : g_net
        assign mismatch[i] = busy & (sensed[i] ^ expected[i]);

        always_ff @(posedge clk) begin
            if (rst || start)      fail_map[i] <= 1'b0;
            else if (step && busy) fail_map[i] <= fail_map[i] | mismatch[i];
        end
    end
endmodule

// File: rtl/ict_vecgen.sv
module ict_vecgen
    import itv_pkg::*;
#(
    parameter int NETS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode_sel,
    input  logic              step,
    input  logic [NETS-1:0]   sensed,
    output logic [NETS-1:0]   drive_vec,
    output logic              busy,
    output logic              done,
    output logic [NETS-1:0]   mismatch,
    output logic [NETS-1:0]   fail_map
);
    localparam int CW      = idx_bits(NETS);
    localparam int MAX_LEN = (NETS > 2 * CW + 2) ? NETS : 2 * CW + 2;
    localparam int STW     = $clog2(MAX_LEN + 1);

    code_mode_e     mode_q;
    logic [STW-1:0] idx;
    run_state_t     st;

    itv_seq #(.NETS(NETS), .STW(STW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .mode_raw(mode_sel),
        .step(step), .mode_q(mode_q), .idx(idx), .st(st)
    );

    itv_pattern #(.NETS(NETS), .STW(STW)) u_pat (
        .mode(mode_q), .idx(idx), .busy(st.busy), .vec(drive_vec)
    );

    itv_compare #(.NETS(NETS)) u_cmp (
        .clk(clk), .rst(rst), .start(start), .step(step), .busy(st.busy),
        .expected(drive_vec), .sensed(sensed),
        .mismatch(mismatch), .fail_map(fail_map)
    );

    assign busy = st.busy;
    assign done = st.done;
endmodule

// File: rtl/ict_vecgen_checker.sv
module ict_vecgen_checker
    import itv_pkg::*;
#(
    parameter int NETS = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [2:0]      mode_sel,
    input logic            busy,
    input logic            done,
    input logic [NETS-1:0] drive_vec,
    input logic [NETS-1:0] fail_map,
    input code_mode_e      mode_q
);
    a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> drive_vec == '0);

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (fail_map == '0) && busy && !done);

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        !start |=> ((fail_map & $past(fail_map)) == $past(fail_map)));

    a_r7_walk_onehot: assert property (@(posedge clk) disable iff (rst)
        (busy && mode_q == CODE_WALK) |-> $countones(drive_vec) == 1);

    a_r6_ext_first_zero: assert property (@(posedge clk) disable iff (rst)
        (start && mode_sel == 3'd3) |=> drive_vec == '0);
endmodule

bind ict_vecgen ict_vecgen_checker #(.NETS(NETS)) u_chk (
    .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
    .busy(busy), .done(done), .drive_vec(drive_vec),
    .fail_map(fail_map), .mode_q(mode_q)
);

// File: tb/ict_vecgen_bench.sv
module ict_vecgen_bench;
    localparam int NETS   = 8;
    localparam int CW     = 3;
    localparam int MCW    = 4;
    localparam int CLK_NS = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [2:0]      mode_sel = 3'd0;
    logic            step = 1'b0;
    logic [NETS-1:0] sensed = '0;
    logic [NETS-1:0] drive_vec, mismatch, fail_map;
    logic            busy, done;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    ict_vecgen #(.NETS(NETS)) u_ict_vecgen (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .step(step), .sensed(sensed), .drive_vec(drive_vec),
        .busy(busy), .done(done), .mismatch(mismatch), .fail_map(fail_map)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int len_of(int m);
        case (m)
            1: return MCW;
            2: return 2 * CW;
            3: return 2 * CW + 2;
            4: return NETS;
            default: return CW;
        endcase
    endfunction

    function automatic bit msb_first(int v, int w, int k);
        return ((v >> (w - 1 - k)) & 1) == 1;
    endfunction

    function automatic logic [NETS-1:0] exp_vec(int m, int k);
        logic [NETS-1:0] v;
        for (int i = 0; i < NETS; i++) begin
            case (m)
                1: v[i] = msb_first(i + 1, MCW, k);
                2: v[i] = (k < CW) ? msb_first(i, CW, k) : !msb_first(i, CW, k - CW);
                3: v[i] = (k == 0) ? 1'b0 : (k == 1) ? 1'b1 :
                          (k < CW + 2) ? msb_first(i, CW, k - 2) : !msb_first(i, CW, k - 2 - CW);
                4: v[i] = (i == k);
                default: v[i] = msb_first(i, CW, k);
            endcase
        end
        return v;
    endfunction

    function automatic string req_of(int m);
        case (m)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(busy == 0 && done == 0, "R1 status", {busy, done}, 0);
        check(drive_vec == 0 && mismatch == 0 && fail_map == 0, "R1 vectors",
              {drive_vec, mismatch, fail_map}, 0);
    endtask

    // full run with an optional corrupted step
    task automatic run_seq(input logic [2:0] raw, input int inj_step,
                           input logic [NETS-1:0] inj_mask);
        int m;
        int len;
        logic [NETS-1:0] emap;
        logic [NETS-1:0] ev;
        logic [NETS-1:0] seen_one, seen_zero;
        int ones [NETS];
        m = (raw > 4) ? 0 : int'(raw);
        len = len_of(m);
        emap = '0; seen_one = '0; seen_zero = '0;
        for (int i = 0; i < NETS; i++) ones[i] = 0;
        @(negedge clk);
        mode_sel = raw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1 && done == 0 && fail_map == 0, "R2 start state",
              {busy, done, fail_map}, {2'b10, {NETS{1'b0}}});
        for (int k = 0; k < len; k++) begin
            ev = exp_vec(m, k);
            check(drive_vec == ev, req_of(m), drive_vec, ev);
            check(done == 0, "R8 done early", done, 0);
            seen_one |= drive_vec; seen_zero |= ~drive_vec;
            for (int i = 0; i < NETS; i++) ones[i] += drive_vec[i];
            sensed = ev ^ ((k == inj_step) ? inj_mask : '0);
            step = 1'b1;
            #1;
            check(mismatch == ((k == inj_step) ? inj_mask : '0), "R9 mismatch",
                  mismatch, (k == inj_step) ? inj_mask : '0);
            emap |= (k == inj_step) ? inj_mask : '0;
            @(negedge clk);
            step = 1'b0;
            sensed = '0;
            #1;
        end
        check(done == 1 && busy == 0, "R8 end", {busy, done}, 2'b01);
        check(drive_vec == 0, "R8 idle drive", drive_vec, 0);
        check(fail_map == emap, "R10 map", fail_map, emap);
        if (m == 1)
            check((seen_one & seen_zero) == '1, "R4 no constant code",
                  seen_one & seen_zero, '1);
        if (m == 2)
            for (int i = 0; i < NETS; i++)
                check(ones[i] == CW, "R5 balanced", ones[i], CW);
    endtask

    task automatic t_idle_step();
        logic [NETS-1:0] keep;
        keep = fail_map;
        @(negedge clk);
        sensed = '1; step = 1'b1;
        #1;
        check(mismatch == 0, "R9 idle", mismatch, 0);
        @(negedge clk);
        step = 1'b0; sensed = '0;
        check(done == 1 && busy == 0 && fail_map == keep && drive_vec == 0,
              "R8 idle step", {done, busy, fail_map}, {2'b10, keep});
    endtask

    task automatic t_restart();
        @(negedge clk);
        mode_sel = 3'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sensed = ~drive_vec; step = 1'b1;
        @(negedge clk);
        step = 1'b0; sensed = '0;
        check(fail_map == '1, "R10 all nets flagged", fail_map, '1);
        mode_sel = 3'd0; start = 1'b1; step = 1'b1;
        @(negedge clk);
        start = 1'b0; step = 1'b0;
        check(fail_map == 0, "R2 restart clears", fail_map, 0);
        check(drive_vec == exp_vec(0, 0) && busy, "R2 restart step0",
              drive_vec, exp_vec(0, 0));
        repeat (CW) begin
            step = 1'b1;
            @(negedge clk);
        end
        step = 1'b0;
        check(done == 1, "R8 after restart", done, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        run_seq(3'd0, -1, '0);
        run_seq(3'd1, -1, '0);
        run_seq(3'd2, 2, 8'h24);
        run_seq(3'd3, 0, 8'h81);
        run_seq(3'd4, 5, 8'h10);
        t_idle_step();
        run_seq(3'd6, 1, 8'h03);
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule